// File: doc/BRIEF.md
# Branch Prediction Stage Sequencer

This block controls the four-step prediction pipeline (s0 through s3) that every sub-predictor of a fetch front end shares. It carries each fetch PC from stage to stage and decides in each cycle which stages advance. A stage advances only when it holds valid data and the stage after it can accept. Each stage from s1 onward returns an opaque predicted next-fetch target for the block it holds. The sequencer chooses the PC that s0 offers from these targets.

The later stages s2 and s3 may disagree with what the stage before them predicted for the same block. When that happens, the sequencer raises a redirect and discards the younger work in flight. It then restarts s0 at the corrected target. An s3 correction beats an s2 correction.

Each fire, redirect and stage-PC output is driven as `NUM_DUP` identical copies, so that separate consumers can each take their own fan-out. The fetch PC restarts from a reset-vector input.

Top module: `bp_stage_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, no stage is valid and no fire or redirect is asserted. The s0 PC equals `reset_vec_i` until s0 first fires.
- R2: When no redirect is asserted, the s0 PC is taken combinationally. It is the s1 target if s1 is valid. Otherwise it is the last s0 PC that was offered and not taken.
- R3: When a stage k (0 to 2) fires, stage k+1 becomes valid on the next cycle and holds the PC that stage k had.
- R4: s0 fires only when `s1_rdy_i` is high and s1 is empty, firing, or being flushed. s1 and s2 fire only when valid, when the next ready input is high, and when the next stage is empty or leaving. A flushed stage never fires. s3 fires when it is valid and `out_rdy_i` is high.
- R5: With a stage's ready input low, nothing enters that stage. A valid stage that neither fires nor is flushed keeps its PC.
- R6: The s2 redirect is high exactly when s2 fires and `s2_tgt_i` differs from the s1 target that was captured when the block left s1.
- R7: The s3 redirect is high exactly when s3 fires and `s3_tgt_i` differs from the s2 target that was captured when the block left s2.
- R8: A redirect clears every stage younger than the redirecting one (s1 for an s2 redirect; s1 and s2 for an s3 redirect) for the next cycle. It also makes the redirecting stage's target the s0 PC in the same cycle.
- R9: An s3 redirect suppresses any s2 redirect and s2 fire in that cycle, and the s0 PC then follows the s3 target.
- R10: Every copy of each duplicated output always equals copy 0.
- R11: Suppose the s3 target is the true successor. Then the sequence of PCs leaving s3 runs from the reset vector along true successors, with none lost or repeated, under any ready pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reset_vec_i | input | PC_W | PC that fetch restarts from after reset |
| s1_rdy_i | input | 1 | s1 sub-predictor can take a new block |
| s2_rdy_i | input | 1 | s2 sub-predictor can take a new block |
| s3_rdy_i | input | 1 | s3 sub-predictor can take a new block |
| out_rdy_i | input | 1 | Consumer after s3 can take a finished block |
| s1_tgt_i | input | PC_W | Next-fetch target predicted by s1 for its block |
| s2_tgt_i | input | PC_W | Next-fetch target predicted by s2 for its block |
| s3_tgt_i | input | PC_W | Next-fetch target predicted by s3 for its block |
| s0_fire_o | output | NUM_DUP | s0 advances into s1 |
| s1_fire_o | output | NUM_DUP | s1 advances into s2 |
| s2_fire_o | output | NUM_DUP | s2 advances into s3 |
| s3_fire_o | output | NUM_DUP | s3 hands its block onward |
| s2_redir_o | output | NUM_DUP | s2 overrides the s1 prediction |
| s3_redir_o | output | NUM_DUP | s3 overrides the s2 prediction |
| s1_valid_o | output | 1 | s1 holds a block |
| s2_valid_o | output | 1 | s2 holds a block |
| s3_valid_o | output | 1 | s3 holds a block |
| s0_pc_o | output | NUM_DUP x PC_W | PC offered at s0 |
| s1_pc_o | output | NUM_DUP x PC_W | PC held in s1 |
| s2_pc_o | output | NUM_DUP x PC_W | PC held in s2 |
| s3_pc_o | output | NUM_DUP x PC_W | PC held in s3 |

## Verification
The hardest case is a redirect that lands while the younger stages are partly stalled. Examples are an s3 correction while s2 waits on a full s3, or an s2 correction in a cycle where s1 cannot accept the corrected PC, so the target must be held for later. The bench drives the targets from the PCs that the design presents, through fixed functions. One function lets s2 wrongly predict taken, another lets s2 miss branches that s3 sees, and the successor rule also produces branches at fixed PC patterns. Thousands of cycles of independently random ready and consumer back-pressure then place these corrections in every combination of stall. A scoreboard follows the true successor chain at the s3 exit.

// File: rtl/bp_pipe_pkg.sv
// Package: shared control bundle for the prediction stage sequencer.
// Assumes: consumers unpack the bundle by field name, never by bit index.
package bp_pipe_pkg;

    // Per-cycle control outcome: four fires and two redirects.
    typedef struct packed {
        logic f0;
        logic f1;
        logic f2;
        logic f3;
        logic r2;
        logic r3;
    } bp_ctl_t;

    localparam int unsigned CTL_W = $bits(bp_ctl_t);

endpackage

// File: rtl/bp_fire_ctrl.sv
// Module: bp_fire_ctrl
// Purpose: combinational advance/flush decision for the four stages.
// Works from the oldest stage back to s0, so that a stage knows whether
// the one after it is leaving or being flushed.
// Assumes: mismatch flags compare each stage's target with the target that
// the stage before it captured for the same block.
module bp_fire_ctrl
    import bp_pipe_pkg::*;
(
    input  logic    run_i,
    input  logic    v1_i,
    input  logic    v2_i,
    input  logic    v3_i,
    input  logic    rdy1_i,
    input  logic    rdy2_i,
    input  logic    rdy3_i,
    input  logic    out_rdy_i,
    input  logic    miss2_i,
    input  logic    miss3_i,
    output bp_ctl_t ctl_o,
    output logic    flush1_o,
    output logic    flush2_o
);

    logic acc1, acc2, acc3;

    // Resolve fires, redirects and acceptance from s3 down to s0.
    always_comb begin
        ctl_o      = '0;
        ctl_o.f3   = v3_i & out_rdy_i;
        ctl_o.r3   = ctl_o.f3 & miss3_i;
        acc3       = rdy3_i & (~v3_i | ctl_o.f3);
        flush2_o   = ctl_o.r3;
        ctl_o.f2   = v2_i & acc3 & ~flush2_o;
        ctl_o.r2   = ctl_o.f2 & miss2_i;
        flush1_o   = ctl_o.r3 | ctl_o.r2;
        acc2       = rdy2_i & (~v2_i | ctl_o.f2 | flush2_o);
        ctl_o.f1   = v1_i & acc2 & ~flush1_o;
        acc1       = rdy1_i & (~v1_i | ctl_o.f1 | flush1_o);
        ctl_o.f0   = run_i & acc1;
    end

endmodule

// File: rtl/bp_stage_slot.sv
// Module: bp_stage_slot
// Purpose: one pipeline stage register (valid bit and fetch PC).
// Assumes: a load in the same cycle as a flush wins, because the
// incoming block is younger than the redirect.
module bp_stage_slot #(
    parameter int unsigned PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [PC_W-1:0] load_pc_i,
    input  logic            leave_i,
    input  logic            flush_i,
    output logic            valid_o,
    output logic [PC_W-1:0] pc_o
);

    // Valid tracking: set on arrival, cleared on departure or flush.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_o <= 1'b0;
        else if (load_i)
            valid_o <= 1'b1;
        else if (leave_i || flush_i)
            valid_o <= 1'b0;
    end

    // PC capture on arrival only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_o <= '0;
        else if (load_i)
            pc_o <= load_pc_i;
    end

endmodule

// File: rtl/bp_dup_fanout.sv
// Module: bp_dup_fanout
// Purpose: drives N identical copies of a bundle.
// Assumes: each copy feeds a separate consumer.
module bp_dup_fanout #(
    parameter int unsigned W = 8,
    parameter int unsigned N = 2
) (
    input  logic [W-1:0]        d_i,
    output logic [N-1:0][W-1:0] q_o
);

    for (genvar g = 0; g < N; g++) begin : g_copy
        assign q_o[g] = d_i;
    end

endmodule

// File: rtl/bp_stage_ctrl.sv
// Module: bp_stage_ctrl (top)
// Purpose: sequences the s0..s3 branch prediction pipeline. It carries the
// fetch PC down the stages, raises s2/s3 redirects on target mismatch,
// flushes younger stages and steers s0 to the corrected target.
// Assumes: stage targets are stable while their stage holds a block;
// reset_vec_i is stable during reset.
module bp_stage_ctrl
    import bp_pipe_pkg::*;
#(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned NUM_DUP = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [PC_W-1:0]              reset_vec_i,
    input  logic                         s1_rdy_i,
    input  logic                         s2_rdy_i,
    input  logic                         s3_rdy_i,
    input  logic                         out_rdy_i,
    input  logic [PC_W-1:0]              s1_tgt_i,
    input  logic [PC_W-1:0]              s2_tgt_i,
    input  logic [PC_W-1:0]              s3_tgt_i,
    output logic [NUM_DUP-1:0]           s0_fire_o,
    output logic [NUM_DUP-1:0]           s1_fire_o,
    output logic [NUM_DUP-1:0]           s2_fire_o,
    output logic [NUM_DUP-1:0]           s3_fire_o,
    output logic [NUM_DUP-1:0]           s2_redir_o,
    output logic [NUM_DUP-1:0]           s3_redir_o,
    output logic                         s1_valid_o,
    output logic                         s2_valid_o,
    output logic                         s3_valid_o,
    output logic [NUM_DUP-1:0][PC_W-1:0] s0_pc_o,
    output logic [NUM_DUP-1:0][PC_W-1:0] s1_pc_o,
    output logic [NUM_DUP-1:0][PC_W-1:0] s2_pc_o,
    output logic [NUM_DUP-1:0][PC_W-1:0] s3_pc_o
);

    localparam int unsigned NUM_STG = 4;
    localparam int unsigned PCB_W   = NUM_STG * PC_W;

    bp_ctl_t         ctl;
    logic            flush1, flush2;
    logic            run_q;
    logic [PC_W-1:0] s0_hold_q;
    logic [PC_W-1:0] tag2_q, tag3_q;
    logic [PC_W-1:0] pc_a [NUM_STG];
    logic [NUM_STG-1:0] fire_v;
    logic [3:1]      valid_v;
    logic [3:1]      flush_v;

    assign fire_v  = {ctl.f3, ctl.f2, ctl.f1, ctl.f0};
    assign flush_v = {1'b0, flush2, flush1};

    // Run flag: holds s0 idle until the first cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    // s0 PC choice: s3 correction, then s2 correction, then s1 target, then held PC.
    always_comb begin
        if (ctl.r3)          pc_a[0] = s3_tgt_i;
        else if (ctl.r2)     pc_a[0] = s2_tgt_i;
        else if (valid_v[1]) pc_a[0] = s1_tgt_i;
        else                 pc_a[0] = s0_hold_q;
    end

    // Held s0 PC: keeps any offer that s0 did not take; reset vector after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        s0_hold_q <= reset_vec_i;
        else if (!ctl.f0)  s0_hold_q <= pc_a[0];
    end

    // Captured predecessor targets that the s2 and s3 blocks are checked against.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag2_q <= '0;
            tag3_q <= '0;
        end else begin
            if (ctl.f1) tag2_q <= s1_tgt_i;
            if (ctl.f2) tag3_q <= s2_tgt_i;
        end
    end

    bp_fire_ctrl u_fire (
        .run_i     (run_q),
        .v1_i      (valid_v[1]),
        .v2_i      (valid_v[2]),
        .v3_i      (valid_v[3]),
        .rdy1_i    (s1_rdy_i),
        .rdy2_i    (s2_rdy_i),
        .rdy3_i    (s3_rdy_i),
        .out_rdy_i (out_rdy_i),
        .miss2_i   (s2_tgt_i != tag2_q),
        .miss3_i   (s3_tgt_i != tag3_q),
        .ctl_o     (ctl),
        .flush1_o  (flush1),
        .flush2_o  (flush2)
    );

    // Stage registers s1..s3, each fed by the fire of the stage before it.
    for (genvar k = 1; k < NUM_STG; k++) begin : g_stage
        bp_stage_slot #(.PC_W(PC_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (fire_v[k-1]),
            .load_pc_i (pc_a[k-1]),
            .leave_i   (fire_v[k]),
            .flush_i   (flush_v[k]),
            .valid_o   (valid_v[k]),
            .pc_o      (pc_a[k])
        );
    end

    assign s1_valid_o = valid_v[1];
    assign s2_valid_o = valid_v[2];
    assign s3_valid_o = valid_v[3];

    logic [NUM_DUP-1:0][CTL_W-1:0] ctl_dup;
    logic [NUM_DUP-1:0][PCB_W-1:0] pc_dup;

    bp_dup_fanout #(.W(CTL_W), .N(NUM_DUP)) u_ctl_dup (
        .d_i (ctl),
        .q_o (ctl_dup)
    );

    bp_dup_fanout #(.W(PCB_W), .N(NUM_DUP)) u_pc_dup (
        .d_i ({pc_a[0], pc_a[1], pc_a[2], pc_a[3]}),
        .q_o (pc_dup)
    );

    // Unpack each copy onto the output ports.
    for (genvar g = 0; g < NUM_DUP; g++) begin : g_out
        bp_ctl_t c;
        assign c             = ctl_dup[g];
        assign s0_fire_o[g]  = c.f0;
        assign s1_fire_o[g]  = c.f1;
        assign s2_fire_o[g]  = c.f2;
        assign s3_fire_o[g]  = c.f3;
        assign s2_redir_o[g] = c.r2;
        assign s3_redir_o[g] = c.r3;
        assign s0_pc_o[g]    = pc_dup[g][4*PC_W-1 -: PC_W];
        assign s1_pc_o[g]    = pc_dup[g][3*PC_W-1 -: PC_W];
        assign s2_pc_o[g]    = pc_dup[g][2*PC_W-1 -: PC_W];
        assign s3_pc_o[g]    = pc_dup[g][PC_W-1 -: PC_W];
    end

endmodule

// File: rtl/bp_stage_ctrl_chk.sv
// Module: bp_stage_ctrl_chk
// Purpose: temporal properties of the stage sequencer, bound to the top.
// Assumes: observes only the top-level ports.
module bp_stage_ctrl_chk #(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned NUM_DUP = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [PC_W-1:0]              reset_vec_i,
    input logic                         s1_rdy_i,
    input logic                         s2_rdy_i,
    input logic                         s3_rdy_i,
    input logic                         out_rdy_i,
    input logic [PC_W-1:0]              s1_tgt_i,
    input logic [PC_W-1:0]              s2_tgt_i,
    input logic [PC_W-1:0]              s3_tgt_i,
    input logic [NUM_DUP-1:0]           s0_fire_o,
    input logic [NUM_DUP-1:0]           s1_fire_o,
    input logic [NUM_DUP-1:0]           s2_fire_o,
    input logic [NUM_DUP-1:0]           s3_fire_o,
    input logic [NUM_DUP-1:0]           s2_redir_o,
    input logic [NUM_DUP-1:0]           s3_redir_o,
    input logic                         s1_valid_o,
    input logic                         s2_valid_o,
    input logic                         s3_valid_o,
    input logic [NUM_DUP-1:0][PC_W-1:0] s0_pc_o,
    input logic [NUM_DUP-1:0][PC_W-1:0] s1_pc_o,
    input logic [NUM_DUP-1:0][PC_W-1:0] s2_pc_o,
    input logic [NUM_DUP-1:0][PC_W-1:0] s3_pc_o
);

    // R1: reset empties the pipe and loads the reset vector.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> !s1_valid_o && !s2_valid_o && !s3_valid_o && s0_pc_o[0] == reset_vec_i);

    // R2: with no correction, a valid s1 supplies the s0 PC.
    a_r2_s1_steers: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid_o && !s2_redir_o[0] && !s3_redir_o[0]) |-> s0_pc_o[0] == s1_tgt_i);

    // R3: a fire from s1 lands its PC in s2.
    a_r3_s1_to_s2: assert property (@(posedge clk) disable iff (!rst_n)
        s1_fire_o[0] |=> s2_valid_o && s2_pc_o[0] == $past(s1_pc_o[0]));

    // R4: s2 and s3 fire only with data and downstream readiness.
    a_r4_s2_fire_ok: assert property (@(posedge clk) disable iff (!rst_n)
        s2_fire_o[0] |-> s2_valid_o && s3_rdy_i);
    a_r4_s3_fire_ok: assert property (@(posedge clk) disable iff (!rst_n)
        s3_fire_o[0] |-> s3_valid_o && out_rdy_i);

    // R5: s1 ready low blocks entry; a stalled s1 keeps its PC.
    a_r5_s1_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_rdy_i |-> !s0_fire_o[0]);
    a_r5_s1_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid_o && !s1_fire_o[0] && !s2_redir_o[0] && !s3_redir_o[0])
        |=> s1_valid_o && $stable(s1_pc_o[0]));

    // R6: an s2 correction needs an s2 fire and steers s0 to the s2 target.
    a_r6_s2_redir: assert property (@(posedge clk) disable iff (!rst_n)
        s2_redir_o[0] |-> s2_fire_o[0] && s0_pc_o[0] == s2_tgt_i);

    // R8: an s3 correction empties s2 and s3 for the next cycle.
    a_r8_s3_flush: assert property (@(posedge clk) disable iff (!rst_n)
        s3_redir_o[0] |=> !s2_valid_o && !s3_valid_o);

    // R9: s3 correction wins over s2.
    a_r9_s3_wins: assert property (@(posedge clk) disable iff (!rst_n)
        s3_redir_o[0] |-> !s2_redir_o[0] && !s2_fire_o[0] && s0_pc_o[0] == s3_tgt_i);

    // R10: every copy equals copy 0.
    for (genvar g = 1; g < NUM_DUP; g++) begin : g_dup
        a_r10_dup_equal: assert property (@(posedge clk) disable iff (!rst_n)
            s0_fire_o[g] == s0_fire_o[0] && s1_fire_o[g] == s1_fire_o[0] &&
            s2_fire_o[g] == s2_fire_o[0] && s3_fire_o[g] == s3_fire_o[0] &&
            s2_redir_o[g] == s2_redir_o[0] && s3_redir_o[g] == s3_redir_o[0] &&
            s0_pc_o[g] == s0_pc_o[0] && s1_pc_o[g] == s1_pc_o[0] &&
            s2_pc_o[g] == s2_pc_o[0] && s3_pc_o[g] == s3_pc_o[0]);
    end

endmodule

bind bp_stage_ctrl bp_stage_ctrl_chk #(.PC_W(PC_W), .NUM_DUP(NUM_DUP)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reset_vec_i (reset_vec_i),
    .s1_rdy_i    (s1_rdy_i),
    .s2_rdy_i    (s2_rdy_i),
    .s3_rdy_i    (s3_rdy_i),
    .out_rdy_i   (out_rdy_i),
    .s1_tgt_i    (s1_tgt_i),
    .s2_tgt_i    (s2_tgt_i),
    .s3_tgt_i    (s3_tgt_i),
    .s0_fire_o   (s0_fire_o),
    .s1_fire_o   (s1_fire_o),
    .s2_fire_o   (s2_fire_o),
    .s3_fire_o   (s3_fire_o),
    .s2_redir_o  (s2_redir_o),
    .s3_redir_o  (s3_redir_o),
    .s1_valid_o  (s1_valid_o),
    .s2_valid_o  (s2_valid_o),
    .s3_valid_o  (s3_valid_o),
    .s0_pc_o     (s0_pc_o),
    .s1_pc_o     (s1_pc_o),
    .s2_pc_o     (s2_pc_o),
    .s3_pc_o     (s3_pc_o)
);

// File: tb/sim_bp_stage_ctrl.sv
// Bench: scoreboard of the committed PC stream plus per-cycle rule checks.
module sim_bp_stage_ctrl;

    localparam int unsigned PC_W = 32;
    localparam int unsigned ND   = 4;
    localparam logic [PC_W-1:0] RV = 32'h0000_1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s1_rdy = 1'b0, s2_rdy = 1'b0, s3_rdy = 1'b0, out_rdy = 1'b0;
    logic [PC_W-1:0] s1_tgt, s2_tgt, s3_tgt;
    logic [ND-1:0] s0f, s1f, s2f, s3f, r2, r3;
    logic v1, v2, v3;
    logic [ND-1:0][PC_W-1:0] pc0, pc1, pc2, pc3;

    always #10 clk = ~clk;

    // Successor rules: true path, s1 guess, s2 guess.
    function automatic logic [PC_W-1:0] f_true(input logic [PC_W-1:0] p);
        return (p[6:4] == 3'd5) ? p + 32'h130 : p + 32'h10;
    endfunction
    function automatic logic [PC_W-1:0] f_s1(input logic [PC_W-1:0] p);
        return p + 32'h10;
    endfunction
    function automatic logic [PC_W-1:0] f_s2(input logic [PC_W-1:0] p);
        if (p[8:4] == 5'h1f) return p + 32'h200;
        return p[9] ? p + 32'h10 : f_true(p);
    endfunction

    assign s1_tgt = f_s1(pc1[0]);
    assign s2_tgt = f_s2(pc2[0]);
    assign s3_tgt = f_true(pc3[0]);

    bp_stage_ctrl #(.PC_W(PC_W), .NUM_DUP(ND)) u0 (
        .clk(clk), .rst_n(rst_n), .reset_vec_i(RV),
        .s1_rdy_i(s1_rdy), .s2_rdy_i(s2_rdy), .s3_rdy_i(s3_rdy), .out_rdy_i(out_rdy),
        .s1_tgt_i(s1_tgt), .s2_tgt_i(s2_tgt), .s3_tgt_i(s3_tgt),
        .s0_fire_o(s0f), .s1_fire_o(s1f), .s2_fire_o(s2f), .s3_fire_o(s3f),
        .s2_redir_o(r2), .s3_redir_o(r3),
        .s1_valid_o(v1), .s2_valid_o(v2), .s3_valid_o(v3),
        .s0_pc_o(pc0), .s1_pc_o(pc1), .s2_pc_o(pc2), .s3_pc_o(pc3)
    );

    int n_chk = 0, n_fail = 0, n_commit = 0, n_r2 = 0, n_r3 = 0;
    bit mon_en = 1'b0;
    logic [PC_W-1:0] exp_q [$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push_exp(input logic [PC_W-1:0] p);
        exp_q.push_back(p);
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    // Monitor: per-cycle rule checks and scoreboard pop at the s3 exit.
    logic p_s0f = 0, p_s1f = 0, p_s2f = 0, p_r2 = 0, p_r3 = 0, p_v1 = 0;
    logic [PC_W-1:0] p_pc0 = RV, p_pc1 = '0, p_pc2 = '0;
    initial begin
        wait (mon_en);
        forever begin
            @(negedge clk);
            #5;
            begin : sample
                bit same = 1'b1;
                logic [PC_W-1:0] e0;
                for (int d = 1; d < ND; d++)
                    if (s0f[d] != s0f[0] || s1f[d] != s1f[0] || s2f[d] != s2f[0] ||
                        s3f[d] != s3f[0] || r2[d] != r2[0] || r3[d] != r3[0] ||
                        pc0[d] != pc0[0] || pc1[d] != pc1[0] || pc2[d] != pc2[0] ||
                        pc3[d] != pc3[0]) same = 1'b0;
                chk(same, "R10", "copies differ", {31'd0, same}, 32'd1);
                // R4 fire preconditions
                if (s0f[0]) chk(s1_rdy && (!v1 || s1f[0] || r2[0] || r3[0]), "R4", "s0 fire", 32'd1, 32'd0);
                if (s1f[0]) chk(v1 && s2_rdy && (!v2 || s2f[0] || r3[0]) && !r2[0] && !r3[0], "R4", "s1 fire", 32'd1, 32'd0);
                if (s2f[0]) chk(v2 && s3_rdy && (!v3 || s3f[0]) && !r3[0], "R4", "s2 fire", 32'd1, 32'd0);
                if (s3f[0]) chk(v3 && out_rdy, "R4", "s3 fire", 32'd1, 32'd0);
                // R5 blocking and holding
                if (!s1_rdy) chk(!s0f[0], "R5", "s0 fired into unready s1", {31'd0, s0f[0]}, 32'd0);
                if (p_v1 && !p_s1f && !p_r2 && !p_r3)
                    chk(v1 && pc1[0] == p_pc1, "R5", "stalled s1 lost its PC", pc1[0], p_pc1);
                // R6, R7 redirect rules
                chk(r2[0] == (s2f[0] && f_s2(pc2[0]) != f_s1(pc2[0])), "R6", "s2 redirect",
                    {31'd0, r2[0]}, {31'd0, s2f[0] && f_s2(pc2[0]) != f_s1(pc2[0])});
                chk(r3[0] == (s3f[0] && f_true(pc3[0]) != f_s2(pc3[0])), "R7", "s3 redirect",
                    {31'd0, r3[0]}, {31'd0, s3f[0] && f_true(pc3[0]) != f_s2(pc3[0])});
                if (r2[0]) n_r2++;
                if (r3[0]) n_r3++;
                // R9 and R2 s0 PC choice
                chk(!(r2[0] && r3[0]), "R9", "both redirects", {31'd0, r2[0]}, 32'd0);
                if (r3[0])      e0 = f_true(pc3[0]);
                else if (r2[0]) e0 = f_s2(pc2[0]);
                else if (v1)    e0 = f_s1(pc1[0]);
                else            e0 = p_pc0;
                chk(pc0[0] == e0, r3[0] ? "R9" : (r2[0] ? "R8" : "R2"), "s0 PC", pc0[0], e0);
                // R3 transfers
                if (p_s0f) chk(v1 && pc1[0] == p_pc0, "R3", "s0 to s1", pc1[0], p_pc0);
                if (p_s1f) chk(v2 && pc2[0] == p_pc1, "R3", "s1 to s2", pc2[0], p_pc1);
                if (p_s2f) chk(v3 && pc3[0] == p_pc2, "R3", "s2 to s3", pc3[0], p_pc2);
                // R8 flushes
                if (p_r3) chk(!v2 && !v3, "R8", "s3 flush", {30'd0, v2, v3}, 32'd0);
                if (p_r2) chk(!v2, "R8", "s2 flush", {31'd0, v2}, 32'd0);
                // R11 scoreboard
                if (s3f[0]) begin
                    logic [PC_W-1:0] e;
                    e = (exp_q.size() != 0) ? exp_q.pop_front() : 32'hdead_beef;
                    chk(pc3[0] == e, "R11", "committed PC", pc3[0], e);
                    push_exp(f_true(pc3[0]));
                    n_commit++;
                end
                p_s0f = s0f[0]; p_s1f = s1f[0]; p_s2f = s2f[0];
                p_r2 = r2[0]; p_r3 = r3[0]; p_v1 = v1;
                p_pc0 = pc0[0]; p_pc1 = pc1[0]; p_pc2 = pc2[0];
            end
        end
    end

    // Watchdog.
    initial begin
        #(64'd20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // Driver: directed start-up, then random back-pressure.
    initial begin
        repeat (3) @(negedge clk);
        #6;
        chk(!v1 && !v2 && !v3, "R1", "valid in reset", {29'd0, v1, v2, v3}, 32'd0);
        chk(s0f == '0 && r2 == '0 && r3 == '0, "R1", "fire in reset", {28'd0, s0f}, 32'd0);
        chk(pc0[0] == RV, "R1", "s0 PC in reset", pc0[0], RV);
        @(negedge clk);
        rst_n = 1'b1;
        mon_en = 1'b1;
        push_exp(RV);
        #6;
        chk(s0f[0] == 1'b0 && !v1, "R1", "first cycle after reset", {31'd0, s0f[0]}, 32'd0);
        repeat (2) begin
            @(negedge clk);
            #6;
            chk(!s0f[0] && !v1, "R5", "s1 not ready", {31'd0, s0f[0]}, 32'd0);
            chk(pc0[0] == RV, "R1", "s0 PC held", pc0[0], RV);
        end
        @(negedge clk);
        s1_rdy = 1'b1;
        #6;
        chk(s0f[0] && pc0[0] == RV, "R4", "s0 fires at reset vector", pc0[0], RV);
        @(negedge clk);
        #6;
        chk(v1 && pc1[0] == RV, "R3", "s1 holds reset vector", pc1[0], RV);
        chk(!s0f[0], "R5", "full s1 blocks s0", {31'd0, s0f[0]}, 32'd0);
        chk(!s1f[0], "R4", "s2 not ready", {31'd0, s1f[0]}, 32'd0);
        chk(pc0[0] == RV + 32'h10, "R2", "s0 follows s1 target", pc0[0], RV + 32'h10);
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            s1_rdy  = ($urandom_range(0, 3) != 0);
            s2_rdy  = ($urandom_range(0, 3) != 0);
            s3_rdy  = ($urandom_range(0, 3) != 0);
            out_rdy = ((i / 150) % 4 == 3) ? ($urandom_range(0, 3) == 0) : ($urandom_range(0, 4) != 0);
        end
        @(negedge clk);
        #7;
        chk(n_commit > 300, "R11", "commit count", n_commit, 301);
        chk(n_r2 > 0, "R6", "s2 redirects seen", n_r2, 1);
        chk(n_r3 > 0, "R7", "s3 redirects seen", n_r3, 1);
        finish_run();
    end

endmodule